// File: doc/BRIEF.md
# Dual-band buffer occupancy monitor

This block sits beside the sample buffers of a receiver that runs one or two frequency bands. For each band it watches the buffer's live fill level (counted in buffer elements, where one element holds two samples, so software multiplies by two), the write strobe into that buffer and the buffer's full indication. From these it keeps a high-water mark of the fill level and a sticky overflow flag. An overflow is a write strobe that arrives while the buffer is full.

A host reads and writes the block through a simple 32-bit, word-addressed register port covering a 64 KiB window (14 word-address bits). The same offset may mean one thing when read and another when written. Offset 0 returns band 0's live level when read. When written, it acts as a single command that clears both high-water marks and both overflow flags. A scratch register lets the host check that the path works. Reads answer one cycle after the request through a small two-state response machine. RD_IDLE moves to RD_RESP on a read request. RD_RESP stays in RD_RESP when another read follows at once, and returns to RD_IDLE otherwise. The number of bands is a parameter. With one band, every band 1 field reads as zero.

Top module: `occw_top`

## Requirements
- R1: After a synchronous reset `rd_valid` is 0, and both high-water marks, both overflow flags and the scratch register read as 0.
- R2: A read of offset 0 returns band 0's live level and a read of offset 1 returns band 1's live level. Each is zero-extended to 32 bits and taken at the clock edge that accepts the read.
- R3: Reads of offsets 2 and 3 return the high-water marks of band 0 and band 1. A mark takes the band's level on every cycle in which the level exceeds the stored value.
- R4: A read of offset 4 returns the overflow flags, with band 0 in bit 0 and band 1 in bit 1 and all other bits 0. A flag sets only when the band's write strobe and full indication are both high in the same cycle.
- R5: An overflow flag stays set after the full indication drops, until the clear command.
- R6: Any write to offset 0 clears both flags and both marks. In that cycle each mark loads the band's current level. The write does not change the live levels returned at offsets 0 and 1. An overflow event in the same cycle as the clear leaves its flag set.
- R7: Offset 7 is a 32-bit scratch register that reads back the last value written to it.
- R8: Reads of any offset other than 0, 1, 2, 3, 4 and 7 return 0. Writes to any offset other than 0 and 7 change nothing. The full 14-bit offset is decoded, so offsets 8 and 15 do not alias offsets 0 and 7.
- R9: `rd_valid` is high in the cycle after each accepted read and low otherwise. Back-to-back reads give back-to-back responses in order, and writes give no response.
- R10: With `NUM_BANDS` = 1, offsets 1 and 3 and bit 1 of offset 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| band_level | input | NUM_BANDS*LEVEL_W | Live fill level per band, band 0 in the low slice |
| band_wr_stb | input | NUM_BANDS | Write strobe into each band's buffer |
| band_full | input | NUM_BANDS | Full indication of each band's buffer |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |

## Verification
The hardest case to reach is the clear command landing in the same cycle as a fresh overflow event, because the flag's outcome depends on which of the two wins. The bench holds band 0 full and issues the write to offset 0 and the write strobe on the same clock edge. It then reads the flags and the marks to confirm that the flag survives and that the mark equals the level at that edge. A second instance built for one band shares the inputs and shows that band 1 stays silent.

// File: rtl/occw_pkg.sv
package occw_pkg;
    localparam int MAX_BANDS = 2;
    localparam int OFS_LVL0  = 0;
    localparam int OFS_LVL1  = 1;
    localparam int OFS_HWM0  = 2;
    localparam int OFS_HWM1  = 3;
    localparam int OFS_OVF   = 4;
    localparam int OFS_SCR   = 7;
    localparam int DATA_W    = 32;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/occw_band.sv
module occw_band #(
    parameter int LEVEL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LEVEL_W-1:0] level_i,
    input  logic               wr_stb_i,
    input  logic               full_i,
    input  logic               clr_i,
    output logic [LEVEL_W-1:0] hwm_o,
    output logic               ovf_o
);
    logic [LEVEL_W-1:0] hwm_q;
    logic               ovf_q;
    logic               ovf_event;

    assign ovf_event = wr_stb_i && full_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            hwm_q <= '0;
        end else if (clr_i) begin
            hwm_q <= level_i;
        end else if (level_i > hwm_q) begin
            hwm_q <= level_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (ovf_event) begin
            ovf_q <= 1'b1;
        end else if (clr_i) begin
            ovf_q <= 1'b0;
        end
    end

    assign hwm_o = hwm_q;
    assign ovf_o = ovf_q;

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_i && full_i) |=> ovf_o);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !clr_i) |=> ovf_o);

    // R3
    hwm_cover_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (hwm_o >= $past(level_i)));

    // R3
    hwm_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clr_i)) |-> (hwm_o >= $past(hwm_o)));

    // R6
    hwm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(clr_i)) |-> (hwm_o == $past(level_i)));
endmodule

// File: rtl/occw_regport.sv
module occw_regport
    import occw_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int LEVEL_W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    input  logic [MAX_BANDS-1:0][LEVEL_W-1:0] cur_lvl,
    input  logic [MAX_BANDS-1:0][LEVEL_W-1:0] hwm_lvl,
    input  logic [MAX_BANDS-1:0]              ovf_flags,
    output logic                              clr_o,
    output logic                              rd_valid,
    output logic [DATA_W-1:0]                 rd_data
);
    rd_state_e         state_q, state_d;
    logic              rd_req, wr_req;
    logic [DATA_W-1:0] scratch_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rd_data_q;

    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RD_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = rd_req ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_req ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    assign rd_valid = (state_q == RD_RESP);
    assign rd_data  = rd_data_q;
    assign clr_o    = wr_req && (req_addr == ADDR_W'(OFS_LVL0));

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
        end else if (wr_req && (req_addr == ADDR_W'(OFS_SCR))) begin
            scratch_q <= req_wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (req_addr)
            ADDR_W'(OFS_LVL0): rd_mux = DATA_W'(cur_lvl[0]);
            ADDR_W'(OFS_LVL1): rd_mux = DATA_W'(cur_lvl[1]);
            ADDR_W'(OFS_HWM0): rd_mux = DATA_W'(hwm_lvl[0]);
            ADDR_W'(OFS_HWM1): rd_mux = DATA_W'(hwm_lvl[1]);
            ADDR_W'(OFS_OVF):  rd_mux = DATA_W'(ovf_flags);
            ADDR_W'(OFS_SCR):  rd_mux = scratch_q;
            default:           rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else if (rd_req) begin
            rd_data_q <= rd_mux;
        end
    end

    // R9
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    // R9
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    // R7
    scratch_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && (req_addr == ADDR_W'(OFS_SCR))) |=> (scratch_q == $past(req_wdata)));

    // R8
    scratch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && (req_addr == ADDR_W'(OFS_SCR))) |=> $stable(scratch_q));
endmodule

// File: rtl/occw_top.sv
module occw_top
    import occw_pkg::*;
#(
    parameter int NUM_BANDS = 2,
    parameter int LEVEL_W   = 16,
    parameter int ADDR_W    = 14
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_BANDS*LEVEL_W-1:0]   band_level,
    input  logic [NUM_BANDS-1:0]           band_wr_stb,
    input  logic [NUM_BANDS-1:0]           band_full,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [DATA_W-1:0]              req_wdata,
    output logic                           rd_valid,
    output logic [DATA_W-1:0]              rd_data
);
    logic [MAX_BANDS-1:0][LEVEL_W-1:0] cur_lvl;
    logic [MAX_BANDS-1:0][LEVEL_W-1:0] hwm_lvl;
    logic [MAX_BANDS-1:0]              ovf_flags;
    logic                              clr;

    for (genvar b = 0; b < MAX_BANDS; b++) begin : g_band
        if (b < NUM_BANDS) begin : g_live
            assign cur_lvl[b] = band_level[b*LEVEL_W +: LEVEL_W];
            occw_band #(.LEVEL_W(LEVEL_W)) u_band (
                .clk      (clk),
                .rst      (rst),
                .level_i  (band_level[b*LEVEL_W +: LEVEL_W]),
                .wr_stb_i (band_wr_stb[b]),
                .full_i   (band_full[b]),
                .clr_i    (clr),
                .hwm_o    (hwm_lvl[b]),
                .ovf_o    (ovf_flags[b])
            );
        end else begin : g_absent
            assign cur_lvl[b]   = '0;
            assign hwm_lvl[b]   = '0;
            assign ovf_flags[b] = 1'b0;
        end
    end

    occw_regport #(.ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) u_regport (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cur_lvl   (cur_lvl),
        .hwm_lvl   (hwm_lvl),
        .ovf_flags (ovf_flags),
        .clr_o     (clr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // R10
    absent_band_chk: assert property (@(posedge clk) disable iff (rst)
        (NUM_BANDS < 2) |-> (hwm_lvl[MAX_BANDS-1] == '0 && !ovf_flags[MAX_BANDS-1]));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !rd_valid);
endmodule

// File: tb/tb_occw_top.sv
module tb_occw_top;
    localparam int LW = 16;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2*LW-1:0] level = '0;
    logic [1:0]    wr = '0;
    logic [1:0]    full = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid, rd_valid1;
    logic [31:0]   rd_data, rd_data1;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] got, got1;
    logic        gotv;

    always #10 clk = ~clk;

    occw_top #(.NUM_BANDS(2), .LEVEL_W(LW), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .band_level(level), .band_wr_stb(wr), .band_full(full),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data));

    occw_top #(.NUM_BANDS(1), .LEVEL_W(LW), .ADDR_W(AW)) dut1 (
        .clk(clk), .rst(rst), .band_level(level[LW-1:0]), .band_wr_stb(wr[0]),
        .band_full(full[0]), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid1),
        .rd_data(rd_data1));

    // lvl0, lvl1, addr, expected
    localparam logic [77:0] VEC [10] = '{
        {16'd5,  16'd9,  14'd0,     32'd5},
        {16'd5,  16'd9,  14'd1,     32'd9},
        {16'd20, 16'd3,  14'd2,     32'd20},
        {16'd20, 16'd3,  14'd3,     32'd9},
        {16'd7,  16'd30, 14'd2,     32'd20},
        {16'd7,  16'd30, 14'd3,     32'd30},
        {16'd7,  16'd30, 14'd4,     32'd0},
        {16'd7,  16'd30, 14'd5,     32'd0},
        {16'd7,  16'd30, 14'd8,     32'd0},
        {16'd7,  16'd30, 14'd16383, 32'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        gotv = rd_valid; got = rd_data; got1 = rd_data1;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R9 write gives no response", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic set_level(input logic [15:0] l0, input logic [15:0] l1);
        @(negedge clk);
        level = {l1, l0};
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
        do_read(14'd2); check("R1 mark 0", got, 32'd0);
        do_read(14'd3); check("R1 mark 1", got, 32'd0);
        do_read(14'd4); check("R1 flags", got, 32'd0);
        do_read(14'd7); check("R1 scratch", got, 32'd0);

        // R2 R3 R8 vector walk
        for (int i = 0; i < 10; i++) begin
            set_level(VEC[i][77:62], VEC[i][61:46]);
            do_read(VEC[i][45:32]);
            check($sformatf("R2/R3/R8 vector %0d", i), got, VEC[i][31:0]);
            check("R9 rd_valid on read", {31'd0, gotv}, 32'd1);
        end

        // R10 single-band instance
        do_read(14'd1); check("R10 one-band level1", got1, 32'd0);
        do_read(14'd3); check("R10 one-band mark1", got1, 32'd0);
        do_read(14'd0); check("R10 one-band level0", got1, 32'd7);

        // R4 strobe without full
        @(negedge clk); wr = 2'b01; @(negedge clk); wr = 2'b00;
        do_read(14'd4); check("R4 strobe alone", got, 32'd0);
        @(negedge clk); full = 2'b01; wr = 2'b01; @(negedge clk); wr = 2'b00;
        do_read(14'd4); check("R4 band0 flag", got, 32'd1);
        @(negedge clk); full = 2'b11; wr = 2'b10; @(negedge clk); wr = 2'b00;
        do_read(14'd4); check("R4 both flags", got, 32'd3);
        check("R10 one-band flags", got1, 32'd1);

        // R5
        @(negedge clk); full = 2'b00;
        repeat (4) @(negedge clk);
        do_read(14'd4); check("R5 sticky", got, 32'd3);

        // R6 clear
        set_level(16'd4, 16'd6);
        do_write(14'd0, 32'hFFFF_FFFF);
        do_read(14'd2); check("R6 mark0 reload", got, 32'd4);
        do_read(14'd3); check("R6 mark1 reload", got, 32'd6);
        do_read(14'd4); check("R6 flags cleared", got, 32'd0);
        do_read(14'd0); check("R6 live level0", got, 32'd4);
        do_read(14'd1); check("R6 live level1", got, 32'd6);

        // R6 clear and overflow in same cycle
        @(negedge clk); full = 2'b01;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 14'd0; wr = 2'b01;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; wr = 2'b00; full = 2'b00;
        do_read(14'd4); check("R6 simultaneous event survives", got, 32'd1);
        do_read(14'd2); check("R6 simultaneous mark", got, 32'd4);

        // R7
        do_write(14'd7, 32'h0000_55AA);
        do_read(14'd7); check("R7 scratch 55AA", got, 32'h0000_55AA);
        do_write(14'd7, 32'hDEAD_BEEF);
        do_read(14'd7); check("R7 scratch DEADBEEF", got, 32'hDEAD_BEEF);

        // R8 writes elsewhere have no effect
        do_write(14'd2, 32'h0000_FFFF);
        do_write(14'd3, 32'h0000_FFFF);
        do_write(14'd4, 32'h0000_0000);
        do_write(14'd15, 32'h0000_1234);
        do_write(14'd8, 32'h0000_0001);
        do_read(14'd2); check("R8 mark0 untouched", got, 32'd4);
        do_read(14'd3); check("R8 mark1 untouched", got, 32'd6);
        do_read(14'd4); check("R8 flags untouched", got, 32'd1);
        do_read(14'd7); check("R8 scratch untouched", got, 32'hDEAD_BEEF);
        do_read(14'd15); check("R8 offset 15 reads zero", got, 32'd0);

        // R9 back-to-back reads
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 14'd0;
        @(negedge clk);
        check("R9 first response valid", {31'd0, rd_valid}, 32'd1);
        check("R9 first response data", rd_data, 32'd4);
        req_addr = 14'd7;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 second response valid", {31'd0, rd_valid}, 32'd1);
        check("R9 second response data", rd_data, 32'hDEAD_BEEF);
        @(negedge clk);
        check("R9 idle after reads", {31'd0, rd_valid}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule